// File: doc/BRIEF.md
# Serial Flash Opcode Upload Capture

This block is the command front end of a serial flash target. It runs on the serial clock SCK and shifts in the 8-bit opcode of each transaction while the chip select is low. It looks the opcode up in a small table of upload opcodes that software can configure. On a hit, it writes the opcode into a command FIFO. The FIFO lives in a region of a shared SRAM, and other datapaths can also write to that SRAM through a mux.

The opcode is committed on the same rising SCK edge that samples its last bit. The mux select that steers the SRAM write port to the upload path comes straight from the SCK-domain decode. Because of this, the write lands even for opcode-only commands such as a chip erase, which end with chip select rising and no ninth clock edge.

A second copy of the datapath select is retimed on the falling SCK edge. This copy is used only by logic on the serial output side, so that it lines up with the output data phase. A host drains the FIFO through a pop port with one cycle of latency. The host also sees empty, full and a sticky overflow flag. In this block the pop port shares the SCK domain, and any domain crossing is done outside it.

Top module: `spi_upcap`

## Requirements
- R1: While `rst_i` is high at a rising SCK edge, the FIFO becomes empty: `empty_o`=1, `full_o`=0 and `overflow_o`=0.
- R2: With `csb_i` low, bits are sampled on rising SCK edges, most significant bit first. If the 8-bit opcode matches a table slot whose enable bit is set, it is written to the FIFO on the 8th rising edge. This holds for a transaction of exactly 8 clocks.
- R3: In a transaction longer than 8 clocks, only the opcode is written, as exactly one FIFO entry. Later bits are ignored.
- R4: Slot i of the table is `upl_tbl_i[8*i+7:8*i]`, and it is enabled by `upl_en_i[i]`. An opcode that matches no enabled slot writes nothing, including an opcode that is held in a disabled slot.
- R5: `csb_i` high asynchronously restarts decoding at bit 0. A transaction abandoned before 8 clocks writes nothing and does not disturb the next one.
- R6: When `alt_we_i` is high and no upload write is in progress, the alternate SRAM write port writes `alt_wdata_i` at `alt_addr_i`. On the rising edge that commits an upload opcode, the mux is on the upload path, and an alternate write in that same cycle is dropped.
- R7: `dp_phase_o` rises on the falling SCK edge after the 8th rising edge of an upload command. It stays 0 for other commands, and it clears as soon as `csb_i` goes high.
- R8: A pop (`rd_en_i` high, FIFO not empty) returns the oldest entry on `rd_data_o` after the next rising edge. Entries come out in the order they were written.
- R9: `full_o` is 1 when `FIFO_DEPTH` entries are held. An upload opcode that arrives while the FIFO is full is dropped and sets `overflow_o`, which stays set until reset.
- R10: A pop request while the FIFO is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck_i | input | 1 | Serial clock; clocks all state |
| rst_i | input | 1 | Synchronous active-high reset of the FIFO state |
| csb_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| upl_tbl_i | input | NUM_SLOTS*8 | Upload opcode table, slot i in bits 8i+7..8i |
| upl_en_i | input | NUM_SLOTS | Enable per table slot |
| alt_we_i | input | 1 | Alternate datapath SRAM write enable |
| alt_addr_i | input | $clog2(SRAM_DEPTH) | Alternate datapath SRAM address |
| alt_wdata_i | input | 8 | Alternate datapath SRAM write data |
| rd_en_i | input | 1 | Host pop request |
| rd_data_o | output | 8 | Popped opcode, registered |
| empty_o | output | 1 | FIFO empty |
| full_o | output | 1 | FIFO full |
| overflow_o | output | 1 | Sticky overflow flag |
| dp_phase_o | output | 1 | Upload datapath select retimed on the falling SCK edge |

## Verification
The bench builds the block with `FIFO_DEPTH`=4, `SRAM_DEPTH`=32, `FIFO_BASE`=24 and `NUM_SLOTS`=4. A depth of four lets a handful of transactions reach full, overflow and pointer wrap. It also lets the random phase run several laps of the FIFO region. Four table slots, one of them disabled, cover hits, misses and the enable mask. The opcode-only transactions stop the clock right after the 8th edge, so a capture that needs a later edge cannot pass.

// File: rtl/spi_upcap_pkg.sv
package spi_upcap_pkg;
  localparam int OPC_W = 8;
  typedef logic [OPC_W-1:0] opc_t;
endpackage

// File: rtl/spi_upcap_shift.sv
module spi_upcap_shift
  import spi_upcap_pkg::*;
#(
  parameter int CNT_W = $clog2(OPC_W + 1)
) (
  input  logic sck_i,
  input  logic csb_i,
  input  logic mosi_i,
  output opc_t opc_next_o,
  output logic last_bit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [OPC_W-2:0] shreg_q;

  assign opc_next_o = {shreg_q, mosi_i};
  assign last_bit_o = ~csb_i & (cnt_q == CNT_W'(OPC_W - 1));

  // chip select high returns decoding to bit 0; counter saturates after opcode
  always_ff @(posedge sck_i or posedge csb_i) begin
    if (csb_i) begin
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (cnt_q != CNT_W'(OPC_W)) begin
      cnt_q   <= cnt_q + 1'b1;
      shreg_q <= opc_next_o[OPC_W-2:0];
    end
  end
endmodule

// File: rtl/spi_upcap_decode.sv
module spi_upcap_decode
  import spi_upcap_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  opc_t                       opc_i,
  input  logic                       last_bit_i,
  input  logic [NUM_SLOTS*OPC_W-1:0] tbl_i,
  input  logic [NUM_SLOTS-1:0]       tbl_en_i,
  output logic                       up_sel_o
);
  logic [NUM_SLOTS-1:0] match;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign match[g] = tbl_en_i[g] & (tbl_i[g*OPC_W +: OPC_W] == opc_i);
  end

  assign up_sel_o = last_bit_i & (|match);
endmodule

// File: rtl/spi_upcap_dpsel.sv
module spi_upcap_dpsel (
  input  logic sck_i,
  input  logic csb_i,
  input  logic up_sel_i,
  output logic dp_phase_o
);
  logic dp_sel_q;

  always_ff @(posedge sck_i or posedge csb_i) begin
    if (csb_i)         dp_sel_q <= 1'b0;
    else if (up_sel_i) dp_sel_q <= 1'b1;
  end

  // output-phase copy, only for serial output side logic
  always_ff @(negedge sck_i or posedge csb_i) begin
    if (csb_i) dp_phase_o <= 1'b0;
    else       dp_phase_o <= dp_sel_q;
  end
endmodule

// File: rtl/spi_upcap_fifoptr.sv
module spi_upcap_fifoptr #(
  parameter int FIFO_DEPTH = 8,
  parameter int PTR_W      = $clog2(FIFO_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             push_i,
  input  logic             pop_req_i,
  output logic             accept_o,
  output logic             pop_o,
  output logic [PTR_W-1:0] waddr_o,
  output logic [PTR_W-1:0] raddr_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             overflow_o
);
  logic [PTR_W:0] wptr_q, rptr_q;

  assign empty_o  = (wptr_q == rptr_q);
  assign full_o   = (wptr_q[PTR_W] != rptr_q[PTR_W]) &&
                    (wptr_q[PTR_W-1:0] == rptr_q[PTR_W-1:0]);
  assign accept_o = push_i & ~full_o;
  assign pop_o    = pop_req_i & ~empty_o;
  assign waddr_o  = wptr_q[PTR_W-1:0];
  assign raddr_o  = rptr_q[PTR_W-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (accept_o)         wptr_q     <= wptr_q + 1'b1;
      if (pop_o)            rptr_q     <= rptr_q + 1'b1;
      if (push_i && full_o) overflow_o <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_upcap_sram.sv
module spi_upcap_sram
  import spi_upcap_pkg::*;
#(
  parameter int SRAM_DEPTH = 64,
  parameter int FIFO_DEPTH = 8,
  parameter int FIFO_BASE  = 32,
  parameter int AW         = $clog2(SRAM_DEPTH),
  parameter int PTR_W      = $clog2(FIFO_DEPTH)
) (
  input  logic             clk_i,
  input  logic             up_sel_i,
  input  logic             up_we_i,
  input  opc_t             up_wdata_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic             alt_we_i,
  input  logic [AW-1:0]    alt_addr_i,
  input  opc_t             alt_wdata_i,
  input  logic             pop_i,
  input  logic [PTR_W-1:0] raddr_i,
  output opc_t             rd_data_o
);
  opc_t        mem [SRAM_DEPTH];
  logic        we;
  logic [AW-1:0] waddr;
  opc_t        wdata;
  logic [AW-1:0] raddr;

  // mux select comes straight from the SCK-domain decode
  always_comb begin
    if (up_sel_i) begin
      we    = up_we_i;
      waddr = AW'(FIFO_BASE) + AW'(waddr_i);
      wdata = up_wdata_i;
    end else begin
      we    = alt_we_i;
      waddr = alt_addr_i;
      wdata = alt_wdata_i;
    end
  end

  assign raddr = AW'(FIFO_BASE) + AW'(raddr_i);

  always_ff @(posedge clk_i) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk_i) begin
    if (pop_i) rd_data_o <= mem[raddr];
  end
endmodule

// File: rtl/spi_upcap.sv
module spi_upcap
  import spi_upcap_pkg::*;
#(
  parameter int SRAM_DEPTH = 64,
  parameter int FIFO_DEPTH = 8,
  parameter int FIFO_BASE  = 32,
  parameter int NUM_SLOTS  = 4,
  parameter int AW         = $clog2(SRAM_DEPTH)
) (
  input  logic                       sck_i,
  input  logic                       rst_i,
  input  logic                       csb_i,
  input  logic                       mosi_i,
  input  logic [NUM_SLOTS*OPC_W-1:0] upl_tbl_i,
  input  logic [NUM_SLOTS-1:0]       upl_en_i,
  input  logic                       alt_we_i,
  input  logic [AW-1:0]              alt_addr_i,
  input  logic [OPC_W-1:0]           alt_wdata_i,
  input  logic                       rd_en_i,
  output logic [OPC_W-1:0]           rd_data_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic                       overflow_o,
  output logic                       dp_phase_o
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);

  opc_t             opc_next;
  logic             last_bit;
  logic             up_sel;
  logic             accept;
  logic             pop;
  logic [PTR_W-1:0] waddr, raddr;

  spi_upcap_shift u_shift (
    .sck_i(sck_i), .csb_i(csb_i), .mosi_i(mosi_i),
    .opc_next_o(opc_next), .last_bit_o(last_bit)
  );

  spi_upcap_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
    .opc_i(opc_next), .last_bit_i(last_bit), .tbl_i(upl_tbl_i),
    .tbl_en_i(upl_en_i), .up_sel_o(up_sel)
  );

  spi_upcap_dpsel u_dpsel (
    .sck_i(sck_i), .csb_i(csb_i), .up_sel_i(up_sel), .dp_phase_o(dp_phase_o)
  );

  spi_upcap_fifoptr #(.FIFO_DEPTH(FIFO_DEPTH)) u_ptr (
    .clk_i(sck_i), .rst_i(rst_i), .push_i(up_sel), .pop_req_i(rd_en_i),
    .accept_o(accept), .pop_o(pop), .waddr_o(waddr), .raddr_o(raddr),
    .full_o(full_o), .empty_o(empty_o), .overflow_o(overflow_o)
  );

  spi_upcap_sram #(
    .SRAM_DEPTH(SRAM_DEPTH), .FIFO_DEPTH(FIFO_DEPTH), .FIFO_BASE(FIFO_BASE)
  ) u_sram (
    .clk_i(sck_i), .up_sel_i(up_sel), .up_we_i(accept), .up_wdata_i(opc_next),
    .waddr_i(waddr), .alt_we_i(alt_we_i), .alt_addr_i(alt_addr_i),
    .alt_wdata_i(alt_wdata_i), .pop_i(pop), .raddr_i(raddr),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/spi_upcap_chk.sv
module spi_upcap_chk (
  input logic sck_i,
  input logic rst_i,
  input logic csb_i,
  input logic rd_en_i,
  input logic up_sel,
  input logic full_o,
  input logic empty_o,
  input logic overflow_o,
  input logic dp_phase_o
);
  AST_OVF_STICKY: assert property (@(posedge sck_i) disable iff (rst_i)
    overflow_o |=> overflow_o); // R9
  AST_FULL_NOT_EMPTY: assert property (@(posedge sck_i) disable iff (rst_i)
    !(full_o && empty_o)); // R9
  AST_ONE_PUSH_PER_CMD: assert property (@(posedge sck_i) disable iff (rst_i)
    up_sel |=> !up_sel); // R3
  AST_PHASE_CLR_CSB: assert property (@(posedge sck_i) disable iff (rst_i)
    csb_i |-> !dp_phase_o); // R7
  AST_EMPTY_POP_NOP: assert property (@(posedge sck_i) disable iff (rst_i)
    (empty_o && rd_en_i && !up_sel) |=> empty_o); // R10
  AST_PUSH_LANDS: assert property (@(posedge sck_i) disable iff (rst_i)
    (up_sel && !full_o) |=> !empty_o); // R2
endmodule

bind spi_upcap spi_upcap_chk u_chk (
  .sck_i(sck_i), .rst_i(rst_i), .csb_i(csb_i), .rd_en_i(rd_en_i),
  .up_sel(up_sel), .full_o(full_o), .empty_o(empty_o),
  .overflow_o(overflow_o), .dp_phase_o(dp_phase_o)
);

// File: tb/spi_upcap_tb_top.sv
`timescale 1ns/1ps
module spi_upcap_tb_top;
  localparam int SRAM_DEPTH = 32;
  localparam int FIFO_DEPTH = 4;
  localparam int FIFO_BASE  = 24;
  localparam int NUM_SLOTS  = 4;
  localparam int AW         = $clog2(SRAM_DEPTH);

  logic clk = 1'b0;
  logic sck_en = 1'b1;
  logic sck;
  logic rst = 1'b1, csb = 1'b1, mosi = 1'b0;
  logic [NUM_SLOTS*8-1:0] tbl;
  logic [NUM_SLOTS-1:0] tbl_en;
  logic alt_we = 1'b0;
  logic [AW-1:0] alt_addr = '0;
  logic [7:0] alt_wdata = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_data;
  logic empty, full, ovf, dp_phase;

  int n_run = 0, n_fail = 0;
  logic [7:0] model_q[$];
  logic model_ovf = 1'b0;
  int wr_count = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;
  assign sck = clk & sck_en;

  assign tbl    = {8'h32, 8'h20, 8'hC7, 8'h02};
  assign tbl_en = 4'b0111;

  spi_upcap #(.SRAM_DEPTH(SRAM_DEPTH), .FIFO_DEPTH(FIFO_DEPTH),
              .FIFO_BASE(FIFO_BASE), .NUM_SLOTS(NUM_SLOTS)) dut_i (
    .sck_i(sck), .rst_i(rst), .csb_i(csb), .mosi_i(mosi),
    .upl_tbl_i(tbl), .upl_en_i(tbl_en), .alt_we_i(alt_we),
    .alt_addr_i(alt_addr), .alt_wdata_i(alt_wdata), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .empty_o(empty), .full_o(full),
    .overflow_o(ovf), .dp_phase_o(dp_phase)
  );

  function automatic bit is_up(logic [7:0] op);
    return (op == 8'h02) || (op == 8'hC7) || (op == 8'h20);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drives one transaction of nbits clocks; returns at a falling edge
  task automatic xfer(logic [7:0] op, int nbits, bit alt_at8, string req);
    bit up;
    up = is_up(op) && nbits >= 8;
    csb = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 8) ? op[7-i] : 1'($urandom);
      if (alt_at8 && i == 7) begin
        alt_we    = 1'b1;
        alt_addr  = AW'(FIFO_BASE + (wr_count % FIFO_DEPTH));
        alt_wdata = 8'hAA;
      end
      @(negedge clk);
      alt_we = 1'b0;
    end
    sck_en = 1'b0;
    #1;
    chk(dp_phase == up, {req, " R7 phase"}, dp_phase, up);
    csb = 1'b1;
    #1;
    chk(dp_phase == 1'b0, "R7 clear on csb", dp_phase, 0);
    if (up) begin
      if (model_q.size() == FIFO_DEPTH) model_ovf = 1'b1;
      else begin
        model_q.push_back(op);
        wr_count++;
      end
    end
    @(negedge clk);
    sck_en = 1'b1;
    @(negedge clk);
    chk(empty == (model_q.size() == 0), {req, " empty"}, empty, model_q.size() == 0);
    chk(full == (model_q.size() == FIFO_DEPTH), {req, " R9 full"}, full,
        model_q.size() == FIFO_DEPTH);
    chk(ovf == model_ovf, {req, " R9 overflow"}, ovf, model_ovf);
  endtask

  task automatic pop_chk(string req);
    logic [7:0] exp;
    bit had;
    had = model_q.size() != 0;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (had) begin
      exp = model_q.pop_front();
      chk(rd_data == exp, {req, " R8 pop data"}, rd_data, exp);
    end else begin
      chk(empty == 1'b1, "R10 pop on empty", empty, 1);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(ovf == 1'b0, "R1 overflow", ovf, 0);
    chk(dp_phase == 1'b0, "R1 phase", dp_phase, 0);

    // R2: opcode-only chip erase, exactly eight clocks
    xfer(8'hC7, 8, 1'b0, "R2 opcode-only");
    pop_chk("R2");
    // R3: page program with trailing address and data bits
    xfer(8'h02, 40, 1'b0, "R3 page program");
    chk(model_q.size() == 1 && !empty, "R3 single entry", empty, 0);
    pop_chk("R3");
    pop_chk("R10");
    // R4: unknown opcode and disabled slot opcode
    xfer(8'h03, 16, 1'b0, "R4 miss");
    xfer(8'h32, 8, 1'b0, "R4 disabled slot");
    // R5: abandoned partial transaction then sector erase
    xfer(8'hFF, 5, 1'b0, "R5 partial");
    xfer(8'h20, 8, 1'b0, "R5 after partial");
    // R6: alternate write in the commit cycle is dropped
    xfer(8'h02, 8, 1'b1, "R6 collide");
    pop_chk("R5");
    pop_chk("R6 collide");
    // R6: idle alternate write lands in an unread slot
    xfer(8'hC7, 8, 1'b0, "R6 setup");
    alt_we = 1'b1;
    alt_addr = AW'(FIFO_BASE + ((wr_count - 1) % FIFO_DEPTH));
    alt_wdata = 8'h5A;
    @(negedge clk);
    alt_we = 1'b0;
    void'(model_q.pop_back());
    model_q.push_back(8'h5A);
    pop_chk("R6 idle alt");
    // R9: fill, overflow, then drain in order
    for (int k = 0; k < FIFO_DEPTH + 1; k++)
      xfer((k % 2) ? 8'hC7 : 8'h02, 8 + (k % 3) * 8, 1'b0, "R9 fill");
    for (int k = 0; k < FIFO_DEPTH + 1; k++) pop_chk("R9 drain");

    // random phase
    for (int t = 0; t < 60; t++) begin
      logic [7:0] op;
      int len;
      case ($urandom % 3)
        0: op = 8'($urandom);
        1: op = 8'h02;
        default: op = ($urandom % 2) ? 8'hC7 : 8'h20;
      endcase
      case ($urandom % 4)
        0: len = 1 + ($urandom % 7);
        1: len = 8;
        default: len = 9 + ($urandom % 24);
      endcase
      xfer(op, len, 1'b0, "R2 random");
      if ($urandom % 3 == 0) pop_chk("R8 random");
    end
    while (model_q.size() != 0) pop_chk("R8 final");
    pop_chk("R10 final");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule